// File: doc/BRIEF.md
# Decoder Host Interrupt and User-Data Buffer

This block gathers event strobes from a video decoder into an eight-bit interrupt register and drives one active-low interrupt line toward a host processor. Each event is gated by a host-written enable mask. Most events are only announced at the next picture-decode sync strobe. Buffer overflow, buffer underflow and bitstream error announce themselves at once.

Bytes of extracted user data go into a 64-entry, 8-bit first-in first-out buffer. The host drains it through a small register port: it reads the byte count, then reads the data address once for each byte. When the buffer fills, an active-low full line asserts and a stall request holds the decoder back until the host removes a byte.

The host port is a plain parallel read/write port. Read data is combinational from the address. The side effects of a read (clearing the interrupt register, popping the buffer) take place at the clock edge that ends the read cycle. Register addresses are: 0 interrupt register (read), 1 event mask (read/write), 2 user-data byte (read, pops), 3 user-data count (read), 4 mode (read/write). Any other address reads as 0.

Top module: `host_event_irq`

## Requirements
- R1: The interrupt register bits are: 0 picture decoded, 1 GOP header, 2 sequence header, 3 sequence end, 4 user data stored, 5 buffer overflow, 6 underflow or PTS received, 7 bitstream error. An event sets its bit only when the mask bit at the same position (address 1) is 1.
- R2: For the ordinary bits (0 to 4, and bit 6 in PTS mode), the interrupt line stays high until a picture-sync strobe arrives while the register is non-zero. It goes low in the cycle after that strobe.
- R3: A masked-in overflow (bit 5), error (bit 7) or underflow (bit 6 with mode bit 4 = 0) drives the interrupt line low in the cycle after the strobe, without waiting for picture sync.
- R4: A host read of address 0 returns the register. At the edge that ends the read, it clears both the register and the line. An event strobed in the same cycle as that read is kept in the register.
- R5: Bit 6 takes the underflow strobe when mode bit 4 (address 4) is 0, and the PTS-received strobe when it is 1. The strobe that is not selected has no effect.
- R6: User-data bytes are read back from address 2 in arrival order, one byte per read. Address 3 reports the number of bytes held (0 to 64).
- R7: While mask bit 4 is 0, incoming user-data bytes are discarded: the count stays unchanged and bit 4 is not set.
- R8: When 64 bytes are held, the full line is low and the stall request is high, and further bytes are dropped. Both lines release in the cycle after a pop.
- R9: A read of address 2 while the buffer is empty returns 0x00 and leaves the count at 0.
- R10: After reset, the interrupt register, mask, mode and count read 0, the interrupt line and full line are high, and the stall request is low.
- R11: Each stored user-data byte sets bit 4 when mask bit 4 is 1.
- R12: The mask and mode registers read back the value last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_picture | input | 1 | Picture decoded strobe |
| ev_gop | input | 1 | GOP header decoded strobe |
| ev_seqhdr | input | 1 | Sequence header decoded strobe |
| ev_seqend | input | 1 | Sequence end decoded strobe |
| ev_overflow | input | 1 | Bitstream buffer overflow strobe |
| ev_underflow | input | 1 | Bitstream buffer underflow strobe |
| ev_pts | input | 1 | PTS received strobe |
| ev_error | input | 1 | Bitstream error strobe |
| pic_sync | input | 1 | Picture-decode sync strobe |
| ud_valid | input | 1 | User-data byte valid |
| ud_byte | input | 8 | User-data byte |
| host_wr | input | 1 | Host write enable |
| host_rd | input | 1 | Host read enable |
| host_addr | input | 3 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data (combinational) |
| irq_n | output | 1 | Interrupt line, active low |
| ufull_n | output | 1 | User-data buffer full, active low |
| dec_stall | output | 1 | Stall request to the decoder |

## Verification
Every state change is due one cycle after its cause. The interrupt line moves at the edge that samples an urgent strobe, a picture-sync strobe or a clearing read. Count, full and stall move at the edge that takes a push or a pop. Read data is valid in the cycle the read is driven, before that edge.

The bench therefore drives inputs just after a rising edge and reads host data at the falling edge of the same cycle. It checks registered outputs just after the next rising edge. A mask sweep over every event bit checks bit setting and the line's deferred or immediate behaviour in the same pass.

// File: rtl/hei_pkg.sv
// Shared constants for the host event interrupt block.
// Assumes an 8-bit interrupt register and a 3-bit host address space.
package hei_pkg;
    localparam int IRQ_W = 8;
    localparam int B_PIC = 0;
    localparam int B_GOP = 1;
    localparam int B_SHD = 2;
    localparam int B_SEN = 3;
    localparam int B_USR = 4;
    localparam int B_OVF = 5;
    localparam int B_UNP = 6;
    localparam int B_ERR = 7;
    // bits that always announce at once; bit 6 is added in underflow mode
    localparam logic [IRQ_W-1:0] URGENT_FIXED = 8'hA0;
    // mode register bit that turns bit 6 into the PTS-received flag
    localparam int MODE_PTS_BIT = 4;

    typedef enum logic [2:0] {
        A_STATUS = 3'd0,
        A_MASK   = 3'd1,
        A_UDATA  = 3'd2,
        A_UCOUNT = 3'd3,
        A_MODE   = 3'd4
    } hreg_e;
endpackage

// File: rtl/hei_user_fifo.sv
// User-data byte buffer: circular store with push/pop and occupancy count.
// Assumes push is dropped when full and pop is ignored when empty;
// the head reads as zero while empty.
module hei_user_fifo #(
    parameter int DEPTH = 64,
    parameter int DW    = 8,
    localparam int AW    = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [DW-1:0]    wdata,
    input  logic             pop,
    output logic [DW-1:0]    head,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic          push_ok;
    logic          pop_ok;

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign push_ok = push & ~full;
    assign pop_ok  = pop & ~empty;
    assign head    = empty ? '0 : mem[rd_ptr];

    // Store an accepted byte at the write pointer.
    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr] <= wdata;
        end
    end

    // Advance pointers and track occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) begin
                wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (pop_ok) begin
                rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            end
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/hei_event_reg.sv
// Interrupt register and line: gates strobes by the mask, accumulates them,
// and drives the line either at picture sync or at once for urgent bits.
// Assumes strobes are one cycle wide; clr is a host read of the register.
module hei_event_reg
    import hei_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IRQ_W-1:0] ev_vec,
    input  logic             ev_pts,
    input  logic             pts_mode,
    input  logic [IRQ_W-1:0] mask,
    input  logic             pic_sync,
    input  logic             clr,
    output logic [IRQ_W-1:0] irq_reg,
    output logic             irq_line
);
    logic [IRQ_W-1:0] raw;
    logic [IRQ_W-1:0] hit;
    logic [IRQ_W-1:0] urgent;
    logic [IRQ_W-1:0] reg_nxt;
    logic             line_nxt;

    // Select the bit 6 source, gate by mask and work out next state.
    always_comb begin
        raw          = ev_vec;
        raw[B_UNP]   = pts_mode ? ev_pts : ev_vec[B_UNP];
        hit          = raw & mask;
        urgent       = URGENT_FIXED;
        urgent[B_UNP] = ~pts_mode;
        reg_nxt      = (clr ? '0 : irq_reg) | hit;
        line_nxt     = (clr ? 1'b0 : irq_line)
                     | (|(hit & urgent))
                     | (pic_sync & (|reg_nxt));
    end

    // Hold register and line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_reg  <= '0;
            irq_line <= 1'b0;
        end else begin
            irq_reg  <= reg_nxt;
            irq_line <= line_nxt;
        end
    end
endmodule

// File: rtl/hei_host_port.sv
// Host register port: holds mask and mode, decodes read side effects,
// and multiplexes read data from the address.
// Assumes host_wr and host_rd are not both high in one cycle.
module hei_host_port
    import hei_pkg::*;
#(
    parameter int DW    = 8,
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_wr,
    input  logic             host_rd,
    input  logic [2:0]       host_addr,
    input  logic [DW-1:0]    host_wdata,
    input  logic [IRQ_W-1:0] irq_reg,
    input  logic [DW-1:0]    ud_head,
    input  logic [CNT_W-1:0] ud_count,
    output logic [IRQ_W-1:0] mask_q,
    output logic [DW-1:0]    mode_q,
    output logic             rd_status,
    output logic             rd_pop,
    output logic [DW-1:0]    host_rdata
);
    assign rd_status = host_rd & (host_addr == A_STATUS);
    assign rd_pop    = host_rd & (host_addr == A_UDATA);

    // Capture host writes to mask and mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            mode_q <= '0;
        end else if (host_wr) begin
            if (host_addr == A_MASK) mask_q <= host_wdata[IRQ_W-1:0];
            if (host_addr == A_MODE) mode_q <= host_wdata;
        end
    end

    // Select read data by address.
    always_comb begin
        case (host_addr)
            A_STATUS: host_rdata = DW'(irq_reg);
            A_MASK:   host_rdata = DW'(mask_q);
            A_UDATA:  host_rdata = ud_head;
            A_UCOUNT: host_rdata = DW'(ud_count);
            A_MODE:   host_rdata = mode_q;
            default:  host_rdata = '0;
        endcase
    end
endmodule

// File: rtl/host_event_irq.sv
// Top: decoder event interrupt controller with user-data byte buffer.
// Assumes all inputs are synchronous to clk and strobes are one cycle wide.
module host_event_irq
    import hei_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ev_picture,
    input  logic          ev_gop,
    input  logic          ev_seqhdr,
    input  logic          ev_seqend,
    input  logic          ev_overflow,
    input  logic          ev_underflow,
    input  logic          ev_pts,
    input  logic          ev_error,
    input  logic          pic_sync,
    input  logic          ud_valid,
    input  logic [DW-1:0] ud_byte,
    input  logic          host_wr,
    input  logic          host_rd,
    input  logic [2:0]    host_addr,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    output logic          irq_n,
    output logic          ufull_n,
    output logic          dec_stall
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [IRQ_W-1:0] mask_q;
    logic [DW-1:0]    mode_q;
    logic [IRQ_W-1:0] irq_reg;
    logic             irq_line;
    logic             rd_status;
    logic             rd_pop;
    logic [DW-1:0]    ud_head;
    logic [CNT_W-1:0] ud_count;
    logic             ud_full;
    logic             ud_empty;
    logic             ud_push;
    logic             ud_stored;
    logic [IRQ_W-1:0] ev_vec;

    // discard user data unless its interrupt is enabled
    assign ud_push   = ud_valid & mask_q[B_USR];
    assign ud_stored = ud_push & ~ud_full;
    assign ev_vec    = {ev_error, ev_underflow, ev_overflow, ud_stored,
                        ev_seqend, ev_seqhdr, ev_gop, ev_picture};

    hei_host_port #(.DW(DW), .CNT_W(CNT_W)) u_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .irq_reg    (irq_reg),
        .ud_head    (ud_head),
        .ud_count   (ud_count),
        .mask_q     (mask_q),
        .mode_q     (mode_q),
        .rd_status  (rd_status),
        .rd_pop     (rd_pop),
        .host_rdata (host_rdata)
    );

    hei_event_reg u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev_vec   (ev_vec),
        .ev_pts   (ev_pts),
        .pts_mode (mode_q[MODE_PTS_BIT]),
        .mask     (mask_q),
        .pic_sync (pic_sync),
        .clr      (rd_status),
        .irq_reg  (irq_reg),
        .irq_line (irq_line)
    );

    hei_user_fifo #(.DEPTH(DEPTH), .DW(DW)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (ud_push),
        .wdata (ud_byte),
        .pop   (rd_pop),
        .head  (ud_head),
        .count (ud_count),
        .full  (ud_full),
        .empty (ud_empty)
    );

    assign irq_n     = ~irq_line;
    assign ufull_n   = ~ud_full;
    assign dec_stall = ud_full;
endmodule

// File: rtl/host_event_irq_chk.sv
// Property checker for host_event_irq, attached by bind.
// Assumes it observes the top's ports and a few internal registers.
module host_event_irq_chk #(
    parameter int DEPTH = 64,
    parameter int CNT_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             host_rd,
    input logic [2:0]       host_addr,
    input logic [7:0]       host_rdata,
    input logic             pic_sync,
    input logic             ev_any,
    input logic             ev_overflow,
    input logic             ev_underflow,
    input logic             ev_error,
    input logic             ud_valid,
    input logic             irq_n,
    input logic             dec_stall,
    input logic [7:0]       mask_q,
    input logic [7:0]       irq_reg,
    input logic [CNT_W-1:0] ud_count
);
    p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ud_count <= CNT_W'(DEPTH));

    p_full_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dec_stall |=> ud_count <= $past(ud_count));

    p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr == 3'd0 && !ev_any && !pic_sync && !ud_valid)
        |=> (irq_n && irq_reg == 8'h00));

    p_urgent_error_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_error && mask_q[7]) |=> !irq_n);

    p_quiet_line_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_n && !pic_sync && !ev_overflow && !ev_underflow && !ev_error)
        |=> irq_n);

    p_discard_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!mask_q[4] && !(host_rd && host_addr == 3'd2)) |=> $stable(ud_count));

    p_empty_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ud_count == '0 && host_rd && host_addr == 3'd2) |-> host_rdata == 8'h00);
endmodule

bind host_event_irq host_event_irq_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_rd      (host_rd),
    .host_addr    (host_addr),
    .host_rdata   (host_rdata),
    .pic_sync     (pic_sync),
    .ev_any       (ev_picture | ev_gop | ev_seqhdr | ev_seqend |
                   ev_overflow | ev_underflow | ev_pts | ev_error),
    .ev_overflow  (ev_overflow),
    .ev_underflow (ev_underflow),
    .ev_error     (ev_error),
    .ud_valid     (ud_valid),
    .irq_n        (irq_n),
    .dec_stall    (dec_stall),
    .mask_q       (mask_q),
    .irq_reg      (irq_reg),
    .ud_count     (ud_count)
);

// File: tb/host_event_irq_test.sv
// Bench for host_event_irq: mask sweep over every event bit, bit 6 mode,
// same-cycle clear, and a fill/drain of the user-data buffer.
module host_event_irq_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ev_picture = 0, ev_gop = 0, ev_seqhdr = 0, ev_seqend = 0;
    logic       ev_overflow = 0, ev_underflow = 0, ev_pts = 0, ev_error = 0;
    logic       pic_sync = 0, ud_valid = 0;
    logic [7:0] ud_byte = 0;
    logic       host_wr = 0, host_rd = 0;
    logic [2:0] host_addr = 0;
    logic [7:0] host_wdata = 0;
    logic [7:0] host_rdata;
    logic       irq_n, ufull_n, dec_stall;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    host_event_irq uut (.*);

    always #2.5 clk = ~clk;

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic hwrite(input logic [2:0] a, input logic [7:0] d);
        host_wr = 1; host_addr = a; host_wdata = d;
        step();
        host_wr = 0;
    endtask

    task automatic hread(input logic [2:0] a, output logic [7:0] d);
        host_rd = 1; host_addr = a;
        @(negedge clk);
        d = host_rdata;
        step();
        host_rd = 0;
    endtask

    task automatic pulse_ev(input int b);
        case (b)
            0: ev_picture = 1;
            1: ev_gop = 1;
            2: ev_seqhdr = 1;
            3: ev_seqend = 1;
            5: ev_overflow = 1;
            6: ev_underflow = 1;
            7: ev_error = 1;
            default: ev_pts = 1;
        endcase
        step();
        {ev_picture, ev_gop, ev_seqhdr, ev_seqend} = '0;
        {ev_overflow, ev_underflow, ev_pts, ev_error} = '0;
    endtask

    task automatic pulse_sync();
        pic_sync = 1;
        step();
        pic_sync = 0;
    endtask

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 37 + 5) & 8'hFF);
    endfunction

    initial begin
        #500000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic [7:0] m;
        repeat (3) step();
        rst_n = 1;
        step();
        // R10 reset state
        check({7'd0, irq_n}, 8'h01, "R10 irq_n");
        check({7'd0, ufull_n}, 8'h01, "R10 ufull_n");
        check({7'd0, dec_stall}, 8'h00, "R10 dec_stall");
        hread(3'd3, d); check(d, 8'h00, "R10 count");
        hread(3'd0, d); check(d, 8'h00, "R10 status");
        hread(3'd1, d); check(d, 8'h00, "R10 mask");
        hread(3'd4, d); check(d, 8'h00, "R10 mode");
        // R12 readback
        hwrite(3'd1, 8'hA5); hread(3'd1, d); check(d, 8'hA5, "R12 mask");
        hwrite(3'd4, 8'h3C); hread(3'd4, d); check(d, 8'h3C, "R12 mode");
        hwrite(3'd4, 8'h00);
        hread(3'd7, d); check(d, 8'h00, "R12 unmapped");

        // R1 R2 R3 R4 sweep over every decoder event bit and three masks
        for (int b = 0; b < 8; b++) begin
            if (b == 4) continue;
            for (int mi = 0; mi < 3; mi++) begin
                logic set, urg;
                m = (mi == 0) ? ~(8'h01 << b) : (mi == 1) ? (8'h01 << b) : 8'hFF;
                set = m[b];
                urg = (b >= 5);
                hwrite(3'd1, m);
                pulse_ev(b);
                check({7'd0, irq_n}, {7'd0, !(set && urg)}, urg ? "R3 immediate" : "R2 deferred");
                pulse_sync();
                check({7'd0, irq_n}, {7'd0, !set}, "R2 at sync");
                hread(3'd0, d);
                check(d, set ? (8'h01 << b) : 8'h00, "R1 bit set");
                check({7'd0, irq_n}, 8'h01, "R4 line cleared");
                hread(3'd0, d);
                check(d, 8'h00, "R4 register cleared");
            end
        end

        // R5 bit 6 in PTS mode
        hwrite(3'd1, 8'hFF);
        hwrite(3'd4, 8'h10);
        pulse_ev(6);
        check({7'd0, irq_n}, 8'h01, "R5 underflow ignored line");
        hread(3'd0, d); check(d, 8'h00, "R5 underflow ignored");
        pulse_ev(8);
        check({7'd0, irq_n}, 8'h01, "R5 pts deferred");
        pulse_sync();
        check({7'd0, irq_n}, 8'h00, "R5 pts at sync");
        hread(3'd0, d); check(d, 8'h40, "R5 pts bit");
        hwrite(3'd4, 8'h00);
        pulse_ev(8);
        hread(3'd0, d); check(d, 8'h00, "R5 pts ignored in underflow mode");

        // R4 event in the same cycle as the clearing read
        host_rd = 1; host_addr = 3'd0; ev_gop = 1;
        @(negedge clk);
        check(host_rdata, 8'h00, "R4 read during event");
        step();
        host_rd = 0; ev_gop = 0;
        hread(3'd0, d); check(d, 8'h02, "R4 event kept");

        // R7 discard while mask bit 4 clear
        hwrite(3'd1, 8'h00);
        for (int i = 0; i < 5; i++) begin
            ud_valid = 1; ud_byte = pat(i); step();
        end
        ud_valid = 0;
        hread(3'd3, d); check(d, 8'h00, "R7 count unchanged");
        hread(3'd0, d); check(d, 8'h00, "R7 no bit 4");

        // R6 R8 R11 fill past capacity
        hwrite(3'd1, 8'h10);
        for (int i = 0; i < 70; i++) begin
            ud_valid = 1; ud_byte = pat(i); step();
            if (i == 62) check({7'd0, dec_stall}, 8'h00, "R8 not full at 63");
        end
        ud_valid = 0;
        check({7'd0, ufull_n}, 8'h00, "R8 full line");
        check({7'd0, dec_stall}, 8'h01, "R8 stall");
        check({7'd0, irq_n}, 8'h01, "R2 user data deferred");
        hread(3'd3, d); check(d, 8'd64, "R6 count full");
        hread(3'd0, d); check(d, 8'h10, "R11 bit 4");
        for (int i = 0; i < 64; i++) begin
            hread(3'd2, d);
            check(d, pat(i), "R6 order");
            if (i == 0) begin
                check({7'd0, ufull_n}, 8'h01, "R8 full released");
                check({7'd0, dec_stall}, 8'h00, "R8 stall released");
                hread(3'd3, d); check(d, 8'd63, "R6 count after pop");
            end
        end
        // R9 empty read
        hread(3'd2, d); check(d, 8'h00, "R9 empty data");
        hread(3'd3, d); check(d, 8'h00, "R9 empty count");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule